// File: doc/BRIEF.md
# Four-Voice Wavetable Sample Player

This block plays stored sound samples for four independent voices that share one byte-wide synchronous sample memory. A host selects a voice with a 2-bit number, supplies a 16-bit byte address where that voice's sample begins, and chooses whether the sample is stored as signed 8-bit or signed 12-bit words. That single write is enough to make the voice play. No separate start command exists. The new address takes effect at the next sample tick. A voice that is already sounding is restarted from the new address.

On every sample tick the block visits the voices in turn and fetches the next word of each one that is playing. Each word is placed at the top of a 16-bit signed value. The block adds up the playing voices, clamps the sum to the 16-bit signed range, and presents the result as one mono word together with a one-cycle valid strobe. Sounds have no length register. Instead the byte value 0x80 is reserved as a terminator: a voice that fetches it goes silent and releases itself.

Ticks that arrive while a round of fetches is still in progress are ignored. The memory answers a read strobe with data on the following clock cycle.

Top module: `wt_player`

## Requirements
- R1: After synchronous reset, `busy` is 0, `mix_out` is 0x0000 and `mix_valid` is low.
- R2: A pulse on `cfg_we` writes to the voice numbered by `cfg_chan` (0 to 3). That voice's `busy` bit reads 1 in the cycle after the write.
- R3: A written voice starts fetching from the written `cfg_start` at the next `tick`. If the voice is rewritten while playing, the next tick fetches from the new address and not from the old pointer.
- R4: With `cfg_fmt12` = 0, each sample is one signed byte. It appears in the voice's contribution as bits 15:8 with bits 7:0 zero, and the voice pointer advances by one byte per tick.
- R5: With `cfg_fmt12` = 1, each sample takes two consecutive bytes. The first byte holds bits 7:0 of a signed 12-bit value and bits 3:0 of the second byte hold bits 11:8; bits 7:4 of the second byte are ignored. The value appears as bits 15:4 with bits 3:0 zero, and the pointer advances by two bytes.
- R6: When the first byte fetched for a sample equals 0x80, the voice stops, contributes nothing on that tick, and its `busy` bit is 0 when the tick's result is presented. In 12-bit format, a second byte equal to 0x80 does not end the sound.
- R7: A voice that is idle or stopped contributes zero. If no voice plays, the tick's result is 0x0000.
- R8: The sum of the contributions is clamped: a sum above 32767 gives 0x7FFF and a sum below -32768 gives 0x8000.
- R9: Every accepted tick produces exactly one single-cycle `mix_valid` pulse, and `mix_out` holds its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe for one voice |
| cfg_chan | input | 2 | Voice number for the write |
| cfg_start | input | 16 | Byte address where the voice's sample begins |
| cfg_fmt12 | input | 1 | Sample format: 0 = signed 8-bit, 1 = signed 12-bit in two bytes |
| tick | input | 1 | Sample-rate strobe that starts one round of fetches |
| mem_rd | output | 1 | Sample memory read strobe |
| mem_addr | output | 16 | Sample memory byte address |
| mem_data | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 4 | Per-voice flag: playing or armed |
| mix_out | output | 16 | Clamped signed mono sum |
| mix_valid | output | 1 | One-cycle strobe marking a new `mix_out` |

## Verification
The bench fills the sample memory so that the terminator appears often. This catches a player that plays 0x80 as audio, or that skips the terminator check on the first byte of a 12-bit sample. A directed case puts 0x80 and stray upper-nibble bits in the second byte of a 12-bit word. A player that tests both bytes for the terminator, or that keeps the upper nibble, gives a different output word or a wrong busy flag. A second directed case drives all four voices to full positive and full negative values. An adder that wraps instead of clamping, or that clamps after each voice instead of on the total, returns the wrong word. A third case rewrites a sounding voice to a new address and checks that the next tick's output comes from that address and not from the old pointer.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int unsigned SAMP_W = 16;
    localparam logic [7:0]  END_CODE = 8'h80;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CH,
        S_LO,
        S_HI,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic                     valid;
        logic signed [SAMP_W-1:0] val;
    } samp_t;

    function automatic logic signed [SAMP_W-1:0] place8(input logic [7:0] b);
        return {b, {(SAMP_W-8){1'b0}}};
    endfunction

    function automatic logic signed [SAMP_W-1:0] place12(input logic [11:0] w);
        return {w, {(SAMP_W-12){1'b0}}};
    endfunction

endpackage

// File: rtl/wt_chan.sv
module wt_chan #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wr_start,
    input  logic          wr_fmt12,
    input  logic          load,
    input  logic          adv,
    input  logic          step2,
    input  logic          stop,
    output logic [AW-1:0] ptr,
    output logic          fmt12,
    output logic          act,
    output logic          busy
);
    logic          pend;
    logic [AW-1:0] pend_addr;
    logic          pend_fmt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_addr <= '0;
            pend_fmt  <= 1'b0;
            ptr       <= '0;
            fmt12     <= 1'b0;
            act       <= 1'b0;
        end else begin
            if (load && pend) begin
                ptr   <= pend_addr;
                fmt12 <= pend_fmt;
                act   <= 1'b1;
                pend  <= 1'b0;
            end else begin
                if (stop) act <= 1'b0;
                if (adv)  ptr <= ptr + (step2 ? AW'(2) : AW'(1));
            end
            if (we) begin
                pend      <= 1'b1;
                pend_addr <= wr_start;
                pend_fmt  <= wr_fmt12;
            end
        end
    end

    assign busy = act | pend;

endmodule

// File: rtl/wt_seq.sv
module wt_seq
    import wt_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [NCH-1:0]         act,
    input  logic [NCH-1:0]         fmt12,
    input  logic [NCH-1:0][AW-1:0] ptr,
    input  logic [7:0]             mem_data,
    output logic                   mem_rd,
    output logic [AW-1:0]          mem_addr,
    output logic                   load,
    output logic [NCH-1:0]         adv,
    output logic [NCH-1:0]         stop,
    output logic                   step2,
    output logic                   clr,
    output logic                   done,
    output samp_t                  samp
);
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    seq_state_t    st, st_n;
    logic [CW-1:0] ch, ch_n;
    logic [7:0]    lo_q;
    logic          next_ch;

    always_comb begin
        st_n     = st;
        ch_n     = ch;
        mem_rd   = 1'b0;
        mem_addr = ptr[ch];
        load     = 1'b0;
        adv      = '0;
        stop     = '0;
        step2    = 1'b0;
        clr      = 1'b0;
        done     = 1'b0;
        samp     = '0;
        next_ch  = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (tick) begin
                    load = 1'b1;
                    clr  = 1'b1;
                    ch_n = '0;
                    st_n = S_CH;
                end
            end
            S_CH: begin
                if (act[ch]) begin
                    mem_rd = 1'b1;
                    st_n   = S_LO;
                end else begin
                    next_ch = 1'b1;
                end
            end
            S_LO: begin
                if (mem_data == END_CODE) begin
                    stop[ch] = 1'b1;
                    next_ch  = 1'b1;
                end else if (!fmt12[ch]) begin
                    samp.valid = 1'b1;
                    samp.val   = place8(mem_data);
                    adv[ch]    = 1'b1;
                    next_ch    = 1'b1;
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = ptr[ch] + AW'(1);
                    st_n     = S_HI;
                end
            end
            S_HI: begin
                samp.valid = 1'b1;
                samp.val   = place12({mem_data[3:0], lo_q});
                adv[ch]    = 1'b1;
                step2      = 1'b1;
                next_ch    = 1'b1;
            end
            S_DONE: begin
                done = 1'b1;
                st_n = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
        if (next_ch) begin
            if (ch == LAST) begin
                st_n = S_DONE;
            end else begin
                ch_n = ch + CW'(1);
                st_n = S_CH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            ch   <= '0;
            lo_q <= '0;
        end else begin
            st <= st_n;
            ch <= ch_n;
            if (st == S_LO) lo_q <= mem_data;
        end
    end

endmodule

// File: rtl/wt_mix.sv
module wt_mix
    import wt_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  samp_t             samp,
    input  logic              done,
    output logic [SAMP_W-1:0] mix_out,
    output logic              mix_valid
);
    localparam int unsigned AccW = SAMP_W + $clog2(NCH) + 1;

    logic signed [AccW-1:0] acc;
    logic signed [AccW-1:0] maxv, minv;
    logic [SAMP_W-1:0]      clamped;

    assign maxv = {{(AccW-SAMP_W+1){1'b0}}, {(SAMP_W-1){1'b1}}};
    assign minv = {{(AccW-SAMP_W+1){1'b1}}, {(SAMP_W-1){1'b0}}};

    always_comb begin
        if (acc > maxv)      clamped = maxv[SAMP_W-1:0];
        else if (acc < minv) clamped = minv[SAMP_W-1:0];
        else                 clamped = acc[SAMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            mix_out   <= '0;
            mix_valid <= 1'b0;
        end else begin
            mix_valid <= done;
            if (clr)
                acc <= '0;
            else if (samp.valid)
                acc <= acc + {{(AccW-SAMP_W){samp.val[SAMP_W-1]}}, samp.val};
            if (done) mix_out <= clamped;
        end
    end

endmodule

// File: rtl/wt_player.sv
module wt_player
    import wt_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [$clog2(NCH)-1:0]   cfg_chan,
    input  logic [AW-1:0]            cfg_start,
    input  logic                     cfg_fmt12,
    input  logic                     tick,
    output logic                     mem_rd,
    output logic [AW-1:0]            mem_addr,
    input  logic [7:0]               mem_data,
    output logic [NCH-1:0]           busy,
    output logic [SAMP_W-1:0]        mix_out,
    output logic                     mix_valid
);
    logic [NCH-1:0][AW-1:0] ptr_v;
    logic [NCH-1:0]         fmt_v, act_v, adv_v, stop_v;
    logic                   load, step2, clr, done;
    samp_t                  samp;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        wt_chan #(.AW(AW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .we       (cfg_we && (cfg_chan == ($clog2(NCH))'(g))),
            .wr_start (cfg_start),
            .wr_fmt12 (cfg_fmt12),
            .load     (load),
            .adv      (adv_v[g]),
            .step2    (step2),
            .stop     (stop_v[g]),
            .ptr      (ptr_v[g]),
            .fmt12    (fmt_v[g]),
            .act      (act_v[g]),
            .busy     (busy[g])
        );
    end

    wt_seq #(.NCH(NCH), .AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .act      (act_v),
        .fmt12    (fmt_v),
        .ptr      (ptr_v),
        .mem_data (mem_data),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .load     (load),
        .adv      (adv_v),
        .stop     (stop_v),
        .step2    (step2),
        .clr      (clr),
        .done     (done),
        .samp     (samp)
    );

    wt_mix #(.NCH(NCH)) u_mix (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .samp      (samp),
        .done      (done),
        .mix_out   (mix_out),
        .mix_valid (mix_valid)
    );

endmodule

// File: rtl/wt_player_chk.sv
module wt_player_chk #(
    parameter int unsigned NCH = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_we,
    input logic [$clog2(NCH)-1:0] cfg_chan,
    input logic                   mem_rd,
    input logic [NCH-1:0]         busy,
    input logic [15:0]            mix_out,
    input logic                   mix_valid
);
    a_r2_write_arms: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> busy[$past(cfg_chan)]);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        mix_valid |=> !mix_valid);

    a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
        !mix_valid |-> $stable(mix_out));

    a_r7_idle_reads_nothing: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (busy != '0));

    a_r7_silent_when_idle: assert property (@(posedge clk) disable iff (rst)
        (mix_valid && busy == '0) |-> (mix_out == 16'h0000));

endmodule

bind wt_player wt_player_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_chan  (cfg_chan),
    .mem_rd    (mem_rd),
    .busy      (busy),
    .mix_out   (mix_out),
    .mix_valid (mix_valid)
);

// File: tb/sim_wt_player.sv
`timescale 1ns/1ps
module sim_wt_player;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_chan;
    logic [15:0] cfg_start;
    logic        cfg_fmt12;
    logic        tick;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic [3:0]  busy;
    logic [15:0] mix_out;
    logic        mix_valid;

    always #2 clk = ~clk;

    wt_player u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_start(cfg_start), .cfg_fmt12(cfg_fmt12), .tick(tick),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .busy(busy), .mix_out(mix_out), .mix_valid(mix_valid)
    );

    logic [7:0] mem [4096];
    always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr[11:0]];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // bench model of the voices
    logic [15:0] m_ptr [4];
    logic        m_fmt [4];
    logic        m_act [4];
    logic        m_pend [4];
    logic [15:0] m_paddr [4];
    logic        m_pfmt [4];
    logic [15:0] exp_mix;
    logic [3:0]  exp_busy;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_busy();
        logic [3:0] b;
        for (int c = 0; c < 4; c++) b[c] = m_act[c] | m_pend[c];
        return b;
    endfunction

    task automatic model_tick();
        int sum = 0;
        for (int c = 0; c < 4; c++) begin
            if (m_pend[c]) begin
                m_ptr[c] = m_paddr[c]; m_fmt[c] = m_pfmt[c];
                m_act[c] = 1'b1; m_pend[c] = 1'b0;
            end
        end
        for (int c = 0; c < 4; c++) begin
            if (m_act[c]) begin
                logic [7:0] lo, hi;
                lo = mem[m_ptr[c][11:0]];
                if (lo == 8'h80) begin
                    m_act[c] = 1'b0;
                end else if (!m_fmt[c]) begin
                    sum += $signed(lo) * 256;
                    m_ptr[c] = m_ptr[c] + 16'd1;
                end else begin
                    logic [11:0] w;
                    logic [15:0] nxt;
                    nxt = m_ptr[c] + 16'd1;
                    hi = mem[nxt[11:0]];
                    w  = {hi[3:0], lo};
                    sum += $signed(w) * 16;
                    m_ptr[c] = m_ptr[c] + 16'd2;
                end
            end
        end
        if (sum > 32767)       exp_mix = 16'h7FFF;
        else if (sum < -32768) exp_mix = 16'h8000;
        else                   exp_mix = sum[15:0];
        exp_busy = model_busy();
    endtask

    task automatic host_write(input logic [1:0] ch, input logic [15:0] a, input logic f12);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = ch; cfg_start = a; cfg_fmt12 = f12;
        @(negedge clk);
        cfg_we = 1'b0;
        m_pend[ch] = 1'b1; m_paddr[ch] = a; m_pfmt[ch] = f12;
        chk("R2 busy after write", {31'd0, busy[ch]}, 32'd1);
    endtask

    task automatic tick_check(input string req);
        bit seen = 0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
        for (int i = 0; i < 40; i++) begin
            if (mix_valid) begin seen = 1; break; end
            @(negedge clk);
        end
        chk({req, " R9 result strobe"}, {31'd0, seen}, 32'd1);
        chk({req, " mix"}, {16'd0, mix_out}, {16'd0, exp_mix});
        chk({req, " busy"}, {28'd0, busy}, {28'd0, exp_busy});
        @(negedge clk);
        chk("R9 strobe one cycle", {31'd0, mix_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++)
            mem[i] = ($urandom % 16 == 0) ? 8'h80 : 8'($urandom);
        for (int c = 0; c < 4; c++) begin
            m_ptr[c] = '0; m_fmt[c] = 0; m_act[c] = 0;
            m_pend[c] = 0; m_paddr[c] = '0; m_pfmt[c] = 0;
        end
        rst = 1'b1; cfg_we = 0; cfg_chan = 0; cfg_start = 0; cfg_fmt12 = 0; tick = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", {28'd0, busy}, 32'd0);
        chk("R1 mix_out", {16'd0, mix_out}, 32'd0);
        chk("R1 mix_valid", {31'd0, mix_valid}, 32'd0);

        tick_check("R7 all idle");
        chk("R7 idle gives zero", {16'd0, mix_out}, 32'd0);

        // R4 / R6: 8-bit voice then terminator
        mem[12'h100] = 8'h10; mem[12'h101] = 8'hF0; mem[12'h102] = 8'h80;
        host_write(2'd0, 16'h0100, 1'b0);
        tick_check("R4 8-bit");
        chk("R4 positive byte", {16'd0, mix_out}, 32'h1000);
        tick_check("R4 8-bit");
        chk("R4 negative byte", {16'd0, mix_out}, 32'hF000);
        tick_check("R6 end code");
        chk("R6 silent", {16'd0, mix_out}, 32'h0);
        chk("R6 released", {31'd0, busy[0]}, 32'd0);

        // R5 / R6: 12-bit voice, 0x80 as upper byte is not an end
        mem[12'h200] = 8'h34; mem[12'h201] = 8'hA5;
        mem[12'h202] = 8'hFF; mem[12'h203] = 8'hF8;
        mem[12'h204] = 8'h00; mem[12'h205] = 8'h80;
        mem[12'h206] = 8'h80;
        host_write(2'd1, 16'h0200, 1'b1);
        tick_check("R5 12-bit");
        chk("R5 positive word", {16'd0, mix_out}, 32'h5340);
        tick_check("R5 12-bit");
        chk("R5 negative word", {16'd0, mix_out}, 32'h8FF0);
        tick_check("R6 upper byte 0x80");
        chk("R6 upper byte not end", {31'd0, busy[1]}, 32'd1);
        tick_check("R6 12-bit end");
        chk("R6 12-bit released", {31'd0, busy[1]}, 32'd0);

        // R8: clamp both ways
        mem[12'h300] = 8'h7F; mem[12'h301] = 8'h81; mem[12'h302] = 8'h80;
        for (int c = 0; c < 4; c++) host_write(2'(c), 16'h0300, 1'b0);
        tick_check("R8 clamp high");
        chk("R8 clamp high", {16'd0, mix_out}, 32'h7FFF);
        tick_check("R8 clamp low");
        chk("R8 clamp low", {16'd0, mix_out}, 32'h8000);
        tick_check("R7 all ended");

        // R3: restart while playing
        mem[12'h400] = 8'h11; mem[12'h401] = 8'h22; mem[12'h402] = 8'h33;
        mem[12'h410] = 8'h55; mem[12'h411] = 8'h80;
        host_write(2'd2, 16'h0400, 1'b0);
        tick_check("R3 start");
        chk("R3 first sample", {16'd0, mix_out}, 32'h1100);
        tick_check("R3 second");
        host_write(2'd2, 16'h0410, 1'b0);
        tick_check("R3 restart");
        chk("R3 new address", {16'd0, mix_out}, 32'h5500);

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 2 == 0)
                host_write(2'($urandom), 16'($urandom % 4096), 1'($urandom));
            tick_check("R3 R4 R5 R6 R8 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule